// File: doc/BRIEF.md
# Transmit Frame Start Gate with Length Truncation

This block sits between a transmit frame FIFO and the MAC transmit datapath. It decides when the frame at the head of the FIFO may begin to leave, and it caps how many bytes of any frame are passed on. Bytes move through it combinationally, one per cycle. A small state machine tracks whether the gate is idle, forwarding a frame, or discarding the tail of a frame that was cut short.

There are two start policies. In cut-through mode a frame leaves once more of it is buffered than a coded threshold, or at once when the whole frame is already buffered. In store-and-forward mode a frame waits until it is fully buffered. The gate only runs after a one-cycle arm pulse and while the enable is high. Dropping the enable never cuts a frame: the frame in flight finishes and no further frame starts. The length cap is one of three parameterised limits, chosen by the jumbo and long-frame controls and latched when each frame starts.

Top module: `tx_start_gate`

## Requirements
- R1: After a synchronous reset, out_valid, out_sof, out_eof, out_trunc and fifo_ready are all 0, and the gate is not armed.
- R2: No frame starts before a one-cycle arm_pulse has been seen. A pulse in cycle N allows a start from cycle N+1 on, and the armed state then persists.
- R3: While cfg_en is 0 no frame starts. A frame already started when cfg_en falls is forwarded to its end.
- R4: With cfg_sf_mode = 0, a frame starts in the first cycle in which head_count is greater than the threshold. Threshold code c (3 bits) means (c+1)*THR_UNIT bytes, so 000 means THR_UNIT (64 by default).
- R5: With cfg_sf_mode = 0, a frame with head_complete = 1 starts at once, even when head_count does not exceed the threshold.
- R6: With cfg_sf_mode = 1, a frame starts only in a cycle in which head_complete = 1.
- R7: The length limit is LIM_LONG when cfg_long = 1, else LIM_JUMBO when cfg_jumbo = 1, else LIM_STD. The limit is sampled on the first byte of each frame.
- R8: If a frame is longer than the limit, the byte at the limit is sent with out_eof = 1 and out_trunc = 1. The remaining bytes of that frame are read from the FIFO (fifo_ready = 1) and are not sent (out_valid = 0).
- R9: Once a frame has started, every FIFO byte is accepted and sent in the cycle it is valid. out_sof marks the first byte and out_eof the last. A frame exactly as long as the limit ends without out_trunc.
- R10: out_data equals fifo_data on every cycle with out_valid = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Transmitter enable |
| cfg_sf_mode | input | 1 | 1: store-and-forward, 0: cut-through threshold |
| cfg_thr_code | input | 3 | Threshold code, (code+1)*THR_UNIT bytes |
| cfg_jumbo | input | 1 | Selects the jumbo length limit |
| cfg_long | input | 1 | Selects the longest length limit (overrides jumbo) |
| arm_pulse | input | 1 | One-cycle pulse that arms the gate |
| fifo_data | input | 8 | Head byte from the FIFO |
| fifo_valid | input | 1 | Head byte is valid |
| fifo_last | input | 1 | Head byte is the last of its frame |
| head_count | input | CNT_W | Bytes of the head frame held in the FIFO |
| head_complete | input | 1 | The whole head frame is held in the FIFO |
| fifo_ready | output | 1 | Head byte is taken this cycle |
| out_data | output | 8 | Byte to the MAC |
| out_valid | output | 1 | out_data is valid |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame as sent |
| out_trunc | output | 1 | Frame was cut at the length limit |

## Verification
The bench builds the gate with THR_UNIT = 8 and limits of 24, 40 and 56 bytes. All eight threshold steps and all three truncation limits can then be reached with frames of a few dozen bytes. Frames that are exactly at a limit, one byte frames back to back, and an enable drop in the middle of a frame also fit into a short run. The FIFO model fills at one byte per cycle, so the cut-through start is seen at an exact fill level, one byte above the threshold.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        TFG_IDLE  = 2'd0,
        TFG_SEND  = 2'd1,
        TFG_DRAIN = 2'd2
    } tfg_state_e;

    typedef struct packed {
        logic       en;
        logic       sf_mode;
        logic [2:0] thr_code;
        logic       jumbo;
        logic       long_frm;
    } tfg_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              sof;
        logic              eof;
        logic              trunc;
    } tfg_beat_t;

    // Threshold in bytes for a 3-bit code: one unit per step, starting at one unit.
    function automatic int unsigned tfg_thr_bytes(input logic [2:0] code,
                                                  input int unsigned unit);
        return (int'(code) + 1) * unit;
    endfunction

    // Length limit picked by the long and jumbo controls; long wins.
    function automatic int unsigned tfg_limit(input logic long_frm, input logic jumbo,
                                              input int unsigned lim_std,
                                              input int unsigned lim_jumbo,
                                              input int unsigned lim_long);
        if (long_frm)   return lim_long;
        else if (jumbo) return lim_jumbo;
        else            return lim_std;
    endfunction

endpackage

// File: rtl/tfg_start_ctl.sv
module tfg_start_ctl
    import tfg_pkg::*;
#(
    parameter int unsigned CNT_W    = 15,
    parameter int unsigned THR_UNIT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  tfg_cfg_t         cfg,
    input  logic             fifo_valid,
    input  logic [CNT_W-1:0] head_count,
    input  logic             head_complete,
    output logic             start_ok
);

    logic             armed_q;
    logic [CNT_W-1:0] thr;
    logic             level_ok;

    always_ff @(posedge clk) begin
        if (rst)      armed_q <= 1'b0;
        else if (arm) armed_q <= 1'b1;
    end

    assign thr = CNT_W'(tfg_thr_bytes(cfg.thr_code, THR_UNIT));

    always_comb begin
        if (cfg.sf_mode) level_ok = head_complete;
        else             level_ok = head_complete || (head_count > thr);
    end

    assign start_ok = armed_q && cfg.en && fifo_valid && level_ok;

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> armed_q); // R2

endmodule

// File: rtl/tfg_len_guard.sv
module tfg_len_guard
    import tfg_pkg::*;
#(
    parameter int unsigned CNT_W     = 15,
    parameter int unsigned LIM_STD   = 2048,
    parameter int unsigned LIM_JUMBO = 10240,
    parameter int unsigned LIM_LONG  = 16384
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic first,
    input  logic long_frm,
    input  logic jumbo,
    output logic at_limit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, lim_q;
    logic [CNT_W-1:0] lim_now, lim_use, pos;

    assign lim_now  = CNT_W'(tfg_limit(long_frm, jumbo, LIM_STD, LIM_JUMBO, LIM_LONG));
    assign lim_use  = first ? lim_now : lim_q;
    assign pos      = first ? ONE : cnt_q + ONE;
    assign at_limit = (pos == lim_use);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= CNT_W'(LIM_STD);
        end else if (take) begin
            cnt_q <= pos;
            if (first) lim_q <= lim_now;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_q); // R7

    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (take && !first) |=> $stable(lim_q)); // R7

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
    import tfg_pkg::*;
#(
    parameter int unsigned CNT_W     = 15,
    parameter int unsigned THR_UNIT  = 64,
    parameter int unsigned LIM_STD   = 2048,
    parameter int unsigned LIM_JUMBO = 10240,
    parameter int unsigned LIM_LONG  = 16384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_sf_mode,
    input  logic [2:0]        cfg_thr_code,
    input  logic              cfg_jumbo,
    input  logic              cfg_long,
    input  logic              arm_pulse,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_valid,
    input  logic              fifo_last,
    input  logic [CNT_W-1:0]  head_count,
    input  logic              head_complete,
    output logic              fifo_ready,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_trunc
);

    tfg_cfg_t   cfg;
    tfg_state_e state_q, state_d;
    tfg_beat_t  beat;
    logic       start_ok, go, take, at_limit;

    assign cfg = '{en: cfg_en, sf_mode: cfg_sf_mode, thr_code: cfg_thr_code,
                   jumbo: cfg_jumbo, long_frm: cfg_long};

    tfg_start_ctl #(.CNT_W(CNT_W), .THR_UNIT(THR_UNIT)) u_start (
        .clk           (clk),
        .rst           (rst),
        .arm           (arm_pulse),
        .cfg           (cfg),
        .fifo_valid    (fifo_valid),
        .head_count    (head_count),
        .head_complete (head_complete),
        .start_ok      (start_ok)
    );

    tfg_len_guard #(.CNT_W(CNT_W), .LIM_STD(LIM_STD), .LIM_JUMBO(LIM_JUMBO),
                    .LIM_LONG(LIM_LONG)) u_len (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .first    (go),
        .long_frm (cfg.long_frm),
        .jumbo    (cfg.jumbo),
        .at_limit (at_limit)
    );

    assign go   = (state_q == TFG_IDLE) && start_ok;
    assign take = go || ((state_q == TFG_SEND) && fifo_valid);

    always_comb begin
        beat.data  = fifo_data;
        beat.valid = take;
        beat.sof   = go;
        beat.eof   = take && (fifo_last || at_limit);
        beat.trunc = take && at_limit && !fifo_last;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TFG_IDLE, TFG_SEND: begin
                if (take) begin
                    if (fifo_last)     state_d = TFG_IDLE;
                    else if (at_limit) state_d = TFG_DRAIN;
                    else               state_d = TFG_SEND;
                end
            end
            TFG_DRAIN: if (fifo_valid && fifo_last) state_d = TFG_IDLE;
            default:   state_d = TFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TFG_IDLE;
        else     state_q <= state_d;
    end

    assign fifo_ready = go || (state_q != TFG_IDLE);
    assign out_data   = beat.data;
    assign out_valid  = beat.valid;
    assign out_sof    = beat.sof;
    assign out_eof    = beat.eof;
    assign out_trunc  = beat.trunc;

    AST_TRUNC_ENDS: assert property (@(posedge clk) disable iff (rst)
        out_trunc |-> (out_eof && out_valid)); // R8

    AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == TFG_DRAIN) |-> (!out_valid && fifo_ready)); // R8

    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> cfg_en); // R3

    AST_SF_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (out_sof && cfg_sf_mode) |-> head_complete); // R6

    AST_THR_MET: assert property (@(posedge clk) disable iff (rst)
        (out_sof && !cfg_sf_mode) |->
        (head_complete || head_count > CNT_W'(tfg_thr_bytes(cfg_thr_code, THR_UNIT)))); // R4

    AST_FLOW_ON: assert property (@(posedge clk) disable iff (rst)
        ((state_q == TFG_SEND) && fifo_valid) |-> (out_valid && fifo_ready)); // R9

    AST_TRUNC_DRAINS: assert property (@(posedge clk) disable iff (rst)
        out_trunc |=> (state_q == TFG_DRAIN)); // R8

endmodule

// File: tb/sim_tx_start_gate.sv
module sim_tx_start_gate;

    localparam int CW = 15, UNIT = 8, LS = 24, LJ = 40, LL = 56;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_en = 0, cfg_sf_mode = 0, cfg_jumbo = 0, cfg_long = 0, arm_pulse = 0;
    logic [2:0] cfg_thr_code = 0;
    logic [7:0] fifo_data = 0;
    logic fifo_valid = 0, fifo_last = 0, head_complete = 0;
    logic [CW-1:0] head_count = 0;
    logic fifo_ready, out_valid, out_sof, out_eof, out_trunc;
    logic [7:0] out_data;

    tx_start_gate #(.CNT_W(CW), .THR_UNIT(UNIT), .LIM_STD(LS), .LIM_JUMBO(LJ),
                    .LIM_LONG(LL)) u0 (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cycle = 0;
    string tag = "R1";

    int flen[0:63], fstart[0:63];
    int nfr = 0, pushed = 0, wr = 0, rd = 0;
    bit wr_en = 1;

    int m_state = 0, m_cnt = 0, m_lim = 0;
    bit m_armed = 0;
    int frames_out = 0, cur_len = 0, last_len = 0, trunc_cnt = 0;
    bit last_trunc = 0;
    int sof_hc = -1;
    bit sof_cmp = 0;

    function automatic int frame_of(int b);
        for (int f = 0; f < nfr; f++)
            if (b >= fstart[f] && b < fstart[f] + flen[f]) return f;
        return -1;
    endfunction

    function automatic logic [7:0] byte_val(int b);
        int f = frame_of(b);
        return 8'((f * 37 + (b - fstart[f]) * 5 + 1) & 255);
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycle);
        end
    endtask

    task automatic push(int len);
        fstart[nfr] = pushed;
        flen[nfr] = len;
        nfr++;
        pushed += len;
    endtask

    // Model and FIFO, stepped once per cycle
    always begin
        int f, hend, cnt_h, thr, lim_now, pos;
        bit v, l, cmp, e_rdy, e_v, e_sof, e_eof, e_tr;
        @(negedge clk);
        cycle++;
        f = (rd < wr) ? frame_of(rd) : frame_of(rd < pushed ? rd : -1);
        if (rd < pushed) begin
            hend  = fstart[f] + flen[f];
            cnt_h = ((wr < hend) ? wr : hend) - rd;
            cmp   = (wr >= hend);
        end else begin
            hend = 0; cnt_h = 0; cmp = 0;
        end
        v = (rd < wr);
        l = v && (rd == hend - 1);
        fifo_valid    = v;
        fifo_last     = l;
        fifo_data     = v ? byte_val(rd) : 8'h00;
        head_count    = CW'(cnt_h);
        head_complete = cmp;
        #1;
        if (rst) begin
            m_state = 0; m_armed = 0; m_cnt = 0;
        end else begin
            thr = (int'(cfg_thr_code) + 1) * UNIT;
            lim_now = cfg_long ? LL : (cfg_jumbo ? LJ : LS);
            e_rdy = 0; e_v = 0; e_sof = 0; e_eof = 0; e_tr = 0;
            case (m_state)
                0: if (m_armed && cfg_en && v && (cfg_sf_mode ? cmp : (cmp || cnt_h > thr))) begin
                       e_rdy = 1; e_v = 1; e_sof = 1; m_lim = lim_now; pos = 1;
                       if (l) begin e_eof = 1; m_state = 0; end
                       else if (pos == m_lim) begin e_eof = 1; e_tr = 1; m_state = 2; end
                       else begin m_cnt = 1; m_state = 1; end
                   end
                1: begin
                       e_rdy = 1;
                       if (v) begin
                           e_v = 1; pos = m_cnt + 1;
                           if (l) begin e_eof = 1; m_state = 0; end
                           else if (pos == m_lim) begin e_eof = 1; e_tr = 1; m_state = 2; end
                           else m_cnt = pos;
                       end
                   end
                default: begin
                       e_rdy = 1;
                       if (v && l) m_state = 0;
                   end
            endcase
            chk(tag, int'(fifo_ready), int'(e_rdy), "fifo_ready");
            chk(tag, int'(out_valid), int'(e_v), "out_valid");
            chk(tag, int'(out_sof), int'(e_sof), "out_sof");
            chk(tag, int'(out_eof), int'(e_eof), "out_eof");
            chk(tag, int'(out_trunc), int'(e_tr), "out_trunc");
            if (e_v) chk("R10", int'(out_data), int'(fifo_data), "out_data");
            if (out_valid) begin
                cur_len = out_sof ? 1 : cur_len + 1;
                if (out_sof) begin sof_hc = cnt_h; sof_cmp = cmp; end
                if (out_eof) begin
                    frames_out++; last_len = cur_len; last_trunc = out_trunc;
                    if (out_trunc) trunc_cnt++;
                end
            end
            if (v && fifo_ready) rd++;
            if (arm_pulse) m_armed = 1;
        end
        if (wr_en && wr < pushed) wr++;
        if (cycle > 50000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <50000 cycles", cycle);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(int maxc);
        int k = 0;
        while ((rd < pushed || m_state != 0) && k < maxc) begin cyc(1); k++; end
        cyc(2);
        checks++;
        if (rd < pushed) begin
            errors++;
            $display("FAIL %s drain: actual rd %0d expected %0d", tag, rd, pushed);
        end
    endtask

    initial begin
        int fo;
        cyc(4);
        rst = 0;
        cyc(1);
        #1;
        chk("R1", int'(out_valid | out_sof | out_eof | out_trunc), 0, "outputs after reset");
        chk("R1", int'(fifo_ready), 0, "fifo_ready after reset");

        // R2: nothing before the arm pulse
        tag = "R2";
        cfg_en = 1; cfg_long = 1; cfg_thr_code = 3'd0;
        push(10);
        cyc(25);
        chk("R2", rd, 0, "bytes taken before arm");
        chk("R2", frames_out, 0, "frames before arm");
        arm_pulse = 1; cyc(1); arm_pulse = 0;
        drain(200);
        chk("R2", last_len, 10, "frame length after arm");

        // R4: cut-through start at threshold code 1 (16 bytes)
        tag = "R4";
        cfg_thr_code = 3'd1;
        push(30);
        drain(200);
        chk("R4", sof_hc, 17, "fill level at start");
        chk("R4", last_len, 30, "frame length");
        cfg_thr_code = 3'd0;
        push(20);
        drain(200);
        chk("R4", sof_hc, 9, "fill level at start, code 000");

        // R5: short complete frame below threshold
        tag = "R5";
        cfg_thr_code = 3'd3;
        push(6);
        drain(200);
        chk("R5", sof_hc, 6, "fill level at start");
        chk("R5", int'(sof_cmp), 1, "complete at start");
        cfg_thr_code = 3'd7;
        push(50);
        drain(300);
        chk("R5", sof_hc, 50, "fill level at start, threshold 64");

        // R6: store-and-forward
        tag = "R6";
        cfg_sf_mode = 1; cfg_thr_code = 3'd0;
        push(20);
        drain(200);
        chk("R6", sof_hc, 20, "fill level at start");
        cfg_sf_mode = 0;

        // R7 / R8: the three limits
        tag = "R8";
        cfg_long = 0; cfg_jumbo = 0;
        fo = trunc_cnt;
        push(30); drain(200);
        chk("R7", last_len, LS, "standard limit length");
        chk("R8", int'(last_trunc), 1, "trunc flag at standard limit");
        cfg_jumbo = 1;
        push(45); drain(200);
        chk("R7", last_len, LJ, "jumbo limit length");
        cfg_long = 1;
        push(60); drain(200);
        chk("R7", last_len, LL, "long limit length");
        chk("R8", trunc_cnt - fo, 3, "truncated frames");

        // R9: exactly at the limit, not truncated
        tag = "R9";
        cfg_long = 0; cfg_jumbo = 0;
        push(LS); drain(200);
        chk("R9", last_len, LS, "length at limit");
        chk("R9", int'(last_trunc), 0, "no trunc at exact limit");
        cfg_long = 1;

        // R3: enable drop mid-frame
        tag = "R3";
        fo = frames_out;
        push(40);
        while (!(m_state == 1)) cyc(1);
        cyc(5);
        cfg_en = 0;
        push(5);
        cyc(80);
        chk("R3", frames_out - fo, 1, "frames done while disabled");
        chk("R3", last_len, 40, "frame in flight completed");
        chk("R3", rd, pushed - 5, "next frame held");
        cfg_en = 1;
        drain(200);
        chk("R3", last_len, 5, "held frame after re-enable");

        // R9: back-to-back short frames
        tag = "R9";
        fo = frames_out;
        wr_en = 0;
        push(1); push(1); push(3);
        wr_en = 1;
        drain(200);
        chk("R9", frames_out - fo, 3, "back-to-back frames");
        chk("R9", last_len, 3, "last short frame length");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule